// File: doc/BRIEF.md
# Modulo 2^32+1 Shift-Add Arithmetic Unit

This unit performs the arithmetic steps of a multiplication-free number transform whose modulus is the Fermat number 2^32+1. Values travel in a 33-bit diminished-one code. A nonzero residue x is stored as x-1 in the low 32 bits with bit 32 clear. Zero is stored with bit 32 set. In this code, multiplying by any power of two needs only a rotation and a selective inversion. Adding needs a 32-bit sum with the carry fed back inverted. No multiplier array is used anywhere.

Each request carries an opcode, up to three operands and a shift amount. The unit computes the result in one cycle and stores it in a single output register. Requests come in on a valid/ready stream and results leave on another valid/ready stream.

A new request is taken when the output register is empty or is being drained in the same cycle. While the consumer holds ready low, the held result and its valid flag stay frozen. The input then shows not-ready, which passes the back-pressure upstream. The sink may hold ready low for any number of cycles without losing data.

There is also a three-operand sum. It uses a carry-save stage whose top carry is folded back, inverted, into bit 0. This lets a butterfly combine three terms with one carry-propagate adder.

Top module: `fmod_alu`

## Requirements
- R1: Opcode 0 (encode) takes in_a as a plain unsigned 33-bit number v. It reduces v modulo 2^32+1 and returns 33'h1_0000_0000 for a zero residue, or the residue minus one otherwise.
- R2: On every coded input, bit 32 set means the value zero, whatever the low bits hold. Every coded result with bit 32 set has all low 32 bits clear.
- R3: Opcode 1 (decode) returns the plain 33-bit residue of in_a: 0 for a zero code, otherwise the low 32 bits plus one.
- R4: Opcode 2 returns the code of (a+b) mod 2^32+1. A zero operand lets the other operand through unchanged in value.
- R5: Opcode 3 returns the code of (a-b) mod 2^32+1. Any nonzero value minus itself gives the zero code.
- R6: Opcode 4 returns the code of -a. A nonzero value has its low 32 bits inverted, and zero stays zero.
- R7: Opcode 5 returns the code of a·2^k mod 2^32+1, for the 6-bit in_shamt k in 0..63. For k = 32 the result is the negation of a.
- R8: Opcode 6 returns the code of (a+b+c) mod 2^32+1, where any operand may be zero.
- R9: Opcode 7 returns in_a in canonical coded form.
- R10: in_ready is high exactly when the output register is empty or out_ready is high. A request accepted at one rising edge shows its result with out_valid high from that edge on.
- R11: While out_valid is high and out_ready is low, out_valid and out_data keep their values.
- R12: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request may be taken this cycle |
| in_op | input | 3 | Operation code (0..7) |
| in_a | input | 33 | First operand (plain value for encode, coded otherwise) |
| in_b | input | 33 | Second coded operand |
| in_c | input | 33 | Third coded operand (three-term sum only) |
| in_shamt | input | 6 | Power-of-two exponent k |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 33 | Coded result, or the plain value for decode |

## Verification
Operands are drawn from a mix of corner codes and random codes. The corners are zero, the value one, the value two, the value 2^32 (all low bits set) and non-canonical zeros with junk in the low bits. Mixing these separates the zero pass-through paths from the end-around carry path. It also reaches the wrap of a+b or a-b onto exactly zero, and the all-ones operand where the inverted carry matters most. Shift amounts cover both halves of the 0..63 range, so plain rotation is tested apart from the extra full inversion. Requests arrive with random gaps and the sink stalls at random, so held results and fresh results are both compared.

// File: rtl/fmod_pkg.sv
package fmod_pkg;

  // Operation codes decoded by the unit
  typedef enum logic [2:0] {
    OP_ENC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_NEG  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SUM3 = 3'd6,
    OP_MOV  = 3'd7
  } fop_e;

  localparam int unsigned DEF_W = 32;

endpackage

// File: rtl/fmod_codec.sv
// Conversion between plain binary and the diminished-one code.
module fmod_codec #(
  parameter int unsigned W = 32
) (
  input  logic [W:0] plain_in,
  input  logic [W:0] code_in,
  output logic [W:0] enc_out,
  output logic [W:0] dec_out
);
  localparam logic [W+1:0] MOD  = {2'b01, {(W-1){1'b0}}, 1'b1};
  localparam logic [W:0]   ZERO = {1'b1, {W{1'b0}}};

  logic [W+1:0] ext;
  logic [W:0]   red;

  always_comb begin
    ext = {1'b0, plain_in};
    // one subtraction suffices: 2^(W+1)-1 < 2*MOD
    red = (ext >= MOD) ? (W+1)'(ext - MOD) : plain_in;
    enc_out = (red == '0) ? ZERO : (W+1)'(red - (W+1)'(1));
  end

  always_comb begin
    if (code_in[W]) dec_out = '0;
    else            dec_out = (W+1)'({1'b0, code_in[W-1:0]} + (W+1)'(1));
  end

endmodule

// File: rtl/fmod_addsub.sv
// Two-operand modular add/subtract with inverted end-around carry,
// plus negation of the first operand.
module fmod_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W:0] a,
  input  logic [W:0] b,
  input  logic       sub,
  output logic [W:0] sum_out,
  output logic [W:0] neg_out
);
  localparam logic [W:0] ZERO = {1'b1, {W{1'b0}}};

  logic         za, zb;
  logic [W-1:0] bb;
  logic [W:0]   raw;
  logic [W:0]   inc;

  always_comb begin
    za  = a[W];
    zb  = b[W];
    bb  = sub ? ~b[W-1:0] : b[W-1:0];
    raw = {1'b0, a[W-1:0]} + {1'b0, bb};
    // carry clear adds one; a wrap of that increment lands on the zero code
    inc = {1'b0, raw[W-1:0]} + {{W{1'b0}}, ~raw[W]};
    if (za && zb)  sum_out = ZERO;
    else if (za)   sum_out = {1'b0, bb};
    else if (zb)   sum_out = {1'b0, a[W-1:0]};
    else           sum_out = inc;
  end

  always_comb begin
    neg_out = za ? ZERO : {1'b0, ~a[W-1:0]};
  end

  // R5: x - x collapses to the zero code
  always_comb begin
    if (sub && !za && !zb && (a[W-1:0] == b[W-1:0]))
      a_r5_self_cancel: assert (sum_out == ZERO);
  end

endmodule

// File: rtl/fmod_shift.sv
// Multiply by 2^k: rotate left, invert the bits that wrap,
// and invert everything once more when k has its top bit set.
module fmod_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(2*W)
) (
  input  logic [W:0]    a,
  input  logic [SW-1:0] k,
  output logic [W:0]    y
);
  logic [SW-2:0] kk;
  logic [W-1:0]  rot;

  always_comb begin
    kk  = k[SW-2:0];
    rot = (a[W-1:0] << kk) | (~a[W-1:0] >> (W - int'(kk)));
    if (k[SW-1]) rot = ~rot;
    y = a[W] ? {1'b1, {W{1'b0}}} : {1'b0, rot};
  end

  // R7: half a turn (2^W) is the same as negation
  always_comb begin
    if (!a[W] && (int'(k) == W))
      a_r7_half_turn: assert (y == {1'b0, ~a[W-1:0]});
  end

endmodule

// File: rtl/fmod_csa3.sv
// Three-operand modular sum: one carry-save layer with the top carry
// folded back inverted into bit 0, then a single carry-propagate add.
module fmod_csa3 #(
  parameter int unsigned W = 32
) (
  input  logic [W:0] a,
  input  logic [W:0] b,
  input  logic [W:0] c,
  output logic [W:0] y
);
  localparam logic [W+1:0] MOD  = {2'b01, {(W-1){1'b0}}, 1'b1};
  localparam logic [W:0]   ZERO = {1'b1, {W{1'b0}}};

  logic [W-1:0] ta, tb, tc;
  logic [W-1:0] s, maj, cy;
  logic [1:0]   n;
  logic [W:0]   t;
  logic [W+1:0] v;

  always_comb begin
    ta  = a[W] ? '0 : a[W-1:0];
    tb  = b[W] ? '0 : b[W-1:0];
    tc  = c[W] ? '0 : c[W-1:0];
    n   = 2'({1'b0, ~a[W]} + {1'b0, ~b[W]} + {1'b0, ~c[W]});
    s   = ta ^ tb ^ tc;
    maj = (ta & tb) | (ta & tc) | (tb & tc);
    // 2^W == -1: the dropped carry becomes ~carry at bit 0, minus one
    cy  = {maj[W-2:0], ~maj[W-1]};
    t   = {1'b0, s} + {1'b0, cy};
    // coded sum = t + n - 2 (mod 2^W+1), taken from v = t + n
    v   = {1'b0, t} + {{W{1'b0}}, n};
    if (n == 2'd0 || v < (W+2)'(2))      y = ZERO;
    else if (v >= MOD + (W+2)'(2))       y = (W+1)'(v - MOD - (W+2)'(2));
    else                                 y = (W+1)'(v - (W+2)'(2));
  end

endmodule

// File: rtl/fmod_alu.sv
module fmod_alu
  import fmod_pkg::*;
#(
  parameter int unsigned W = DEF_W,
  localparam int unsigned SW = $clog2(2*W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [W:0]    in_a,
  input  logic [W:0]    in_b,
  input  logic [W:0]    in_c,
  input  logic [SW-1:0] in_shamt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W:0]    out_data
);
  localparam logic [W:0] ZERO = {1'b1, {W{1'b0}}};

  fop_e       op;
  logic [W:0] enc_y, dec_y, as_y, neg_y, sh_y, s3_y;
  logic [W:0] res;
  logic       take;

  assign op = fop_e'(in_op);

  fmod_codec #(.W(W)) u_codec (
    .plain_in (in_a),
    .code_in  (in_a),
    .enc_out  (enc_y),
    .dec_out  (dec_y)
  );

  fmod_addsub #(.W(W)) u_addsub (
    .a       (in_a),
    .b       (in_b),
    .sub     (op == OP_SUB),
    .sum_out (as_y),
    .neg_out (neg_y)
  );

  fmod_shift #(.W(W), .SW(SW)) u_shift (
    .a (in_a),
    .k (in_shamt),
    .y (sh_y)
  );

  fmod_csa3 #(.W(W)) u_csa3 (
    .a (in_a),
    .b (in_b),
    .c (in_c),
    .y (s3_y)
  );

  always_comb begin
    unique case (op)
      OP_ENC:          res = enc_y;
      OP_DEC:          res = dec_y;
      OP_ADD, OP_SUB:  res = as_y;
      OP_NEG:          res = neg_y;
      OP_SHL:          res = sh_y;
      OP_SUM3:         res = s3_y;
      default:         res = in_a[W] ? ZERO : in_a;
    endcase
  end

  // one-deep output register with pass-through ready
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r10_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r2_canonical_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (op != OP_DEC) |-> !(out_data[W] && (|out_data[W-1:0])) || $past(op == OP_DEC));

  a_r12_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/fmod_alu_bench.sv
`timescale 1ns/1ps
module fmod_alu_bench;
  localparam int W = 32;
  localparam longint unsigned MODV = 64'h1_0000_0001;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2:0]    in_op = '0;
  logic [W:0]    in_a = '0, in_b = '0, in_c = '0;
  logic [5:0]    in_shamt = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W:0]    out_data;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  fmod_alu u_fmod_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned val(input logic [W:0] d);
    return d[W] ? 64'd0 : {32'd0, d[W-1:0]} + 64'd1;
  endfunction

  function automatic logic [W:0] code(input longint unsigned v);
    return (v == 0) ? {1'b1, 32'd0} : 33'(v - 1);
  endfunction

  function automatic logic [W:0] model(input int op, input logic [W:0] a, b, c,
                                       input int k);
    longint unsigned v;
    case (op)
      0: return code({31'd0, a} % MODV);
      1: return 33'(val(a));
      2: return code((val(a) + val(b)) % MODV);
      3: return code((val(a) + MODV - val(b)) % MODV);
      4: return code((MODV - val(a)) % MODV);
      5: begin
        v = val(a);
        for (int j = 0; j < k; j++) v = (v * 2) % MODV;
        return code(v);
      end
      6: return code((val(a) + val(b) + val(c)) % MODV);
      default: return code(val(a));
    endcase
  endfunction

  function automatic string tag(input int op);
    case (op)
      0: return "R1 encode";
      1: return "R3 decode";
      2: return "R4 add";
      3: return "R5 sub";
      4: return "R6 negate";
      5: return "R7 power-of-two";
      6: return "R8 three-term sum";
      default: return "R9 copy";
    endcase
  endfunction

  function automatic logic [W:0] pick_code();
    case ($urandom % 7)
      0: return {1'b1, 32'd0};
      1: return {1'b0, 32'd0};
      2: return {1'b0, 32'hFFFF_FFFF};
      3: return {1'b1, 32'($urandom) | 32'd1};
      4: return {1'b0, 32'd1};
      default: return {1'b0, 32'($urandom)};
    endcase
  endfunction

  function automatic logic [W:0] pick_plain();
    case ($urandom % 6)
      0: return 33'd0;
      1: return 33'd1;
      2: return 33'h1_0000_0000;
      3: return 33'h1_0000_0001;
      4: return 33'h1_FFFF_FFFF;
      default: return {1'($urandom), 32'($urandom)};
    endcase
  endfunction

  bit          mvalid;
  logic [W:0]  mdata;
  int          mop;

  initial begin
    mvalid = 0; mdata = '0; mop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 valid low in reset", 64'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R12 valid low after reset", 64'(out_valid), 0);
    chk(in_ready == 1'b1, "R12 ready after reset", 64'(in_ready), 1);
    for (int i = 0; i < 4000; i++) begin
      int op;
      bit exp_ready;
      op = (i < 256) ? (i % 8) : int'($urandom % 8);
      in_valid  = ($urandom % 4) != 0;
      in_op     = 3'(op);
      in_a      = (op == 0) ? pick_plain() : pick_code();
      in_b      = pick_code();
      in_c      = pick_code();
      in_shamt  = (i % 5 == 0) ? 6'd32 : 6'($urandom);
      out_ready = ($urandom % 3) != 0;
      #1;
      exp_ready = !mvalid || out_ready;
      chk(in_ready == exp_ready, "R10 in_ready", 64'(in_ready), 64'(exp_ready));
      @(posedge clk);
      if (in_valid && exp_ready) begin
        mvalid = 1;
        mdata  = model(op, in_a, in_b, in_c, int'(in_shamt));
        mop    = op;
      end else if (out_ready) begin
        mvalid = 0;
      end
      @(negedge clk);
      chk(out_valid == mvalid, "R10/R11 out_valid", 64'(out_valid), 64'(mvalid));
      if (mvalid && out_valid) begin
        chk(out_data == mdata, tag(mop), 64'(out_data), 64'(mdata));
        if (mop != 1)
          chk(!(out_data[W] && |out_data[W-1:0]), "R2 canonical zero",
              64'(out_data), 64'(mdata));
      end
    end
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule